// File: doc/BRIEF.md
# Descriptor Ring Doorbell Counter Unit

This block keeps the count bookkeeping for two packet descriptor rings, one inbound (receive) and one outbound (transmit). For each ring, software programs a ring size and then posts entries to hardware by writing a doorbell value. The block holds the number of posted entries that hardware has not yet used. Each time hardware finishes an entry, it sends a one-cycle completion pulse. The pulse uses up one posted entry, advances a tail pointer around the ring, and adds one to a pending-packet count. Software then writes back how many completed packets it has handled, and that value is subtracted from the pending count.

Faulty software requests are flagged and leave the counts untouched. A doorbell that would post more entries than the ring has room for is one such request. Writing back more packets than are pending is the other. Each ring's pending count is also compared against a programmable high-water mark. All of these events, plus a receive-data-drop pulse, land in sticky status bits. The status bits are masked by an enable register and combined into one interrupt line.

A small control state machine has two states, RUN and HELD. It implements a soft reset that keeps every counter and tail pointer at zero. The transitions are:
- RUN_TO_HELD is taken when the control register is written with bit 0 set.
- HELD_TO_RUN is taken when the control register is written with bit 0 clear.

Top module: `ring_doorbell_unit`

## Requirements
- R1: Register addresses (4 bits) are as follows:
  - 0: control, with soft reset in bit 0.
  - 1 and 5: ring size, inbound and outbound.
  - 2 and 6: doorbell on write, posted count on read.
  - 3 and 7: subtract-from-pending on write, pending count on read.
  - 4 and 8: high-water mark.
  - 9: status.
  - 10: interrupt enable.
  - 11 and 12: tail pointer, read only.

  The read data follows `rd_addr` combinationally. A write takes effect at the clock edge on which `wr_en` is sampled high.
- R2: An accepted doorbell adds its value to the ring's posted count. When a completion arrives in the same cycle, the count also loses one, so the result is old + value − 1.
- R3: A completion pulse while the posted count is nonzero does three things: the posted count drops by one, the pending count rises by one, and the tail pointer advances, wrapping from size−1 back to 0. A completion while the posted count is zero changes nothing.
- R4: A doorbell value greater than (size − posted) is discarded and sets status bit 0 (inbound) or bit 1 (outbound). A value exactly equal to the room is accepted.
- R5: A write to a pending register subtracts the value from the count. If the value exceeds the count, the count is left unchanged and status bit 4 (inbound) or bit 5 (outbound) is set.
- R6: Status bit 2 (inbound) or bit 3 (outbound) is set on the clock after the ring's pending count is strictly greater than its high-water mark. Equality does not set it.
- R7: A pulse on `rx_drop` sets status bit 6.
- R8: Status bits are sticky and are cleared by writing 1 to them. If a bit's set condition is present in the same cycle as the clear, the bit stays set.
- R9: `irq` is high exactly when the bitwise AND of the status and enable registers is nonzero.
- R10: After `rst_n`, every register reads zero. While the soft reset is held:
  - posted counts, pending counts and tail pointers are zero;
  - doorbell writes, pending writes and completions are ignored;
  - sizes, high-water marks, enables and status keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | CW | Register read data |
| in_done | input | 1 | Hardware finished one inbound entry |
| out_done | input | 1 | Hardware finished one outbound entry |
| rx_drop | input | 1 | Receive data was dropped |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps outbound ring sizes 1 to 6, sending more completions than there are posted entries. This exposes a tail that fails to wrap, or wraps one entry late, and a design that keeps counting completions after the posted count reaches zero.

It probes doorbells at exactly the free room and one beyond it. This catches an off-by-one that rejects a legal doorbell, or that accepts an oversize one and corrupts the posted count. It also sends a doorbell and a completion in the same cycle, which a design that lets one update override the other would get wrong.

Over-large pending write-backs, a pending count equal to the high-water mark, and a write-1-to-clear that races an active threshold catch three further faults:
- a count that wraps instead of flagging underflow;
- a comparison that uses greater-or-equal;
- a clear that wins over a live set.

// File: rtl/ring_dbell_pkg.sv
package ring_dbell_pkg;
    localparam int ADDR_W = 4;
    localparam int NSTAT  = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_ISIZE = 4'd1,
        A_IDB   = 4'd2,
        A_IPEND = 4'd3,
        A_IHWM  = 4'd4,
        A_OSIZE = 4'd5,
        A_ODB   = 4'd6,
        A_OPEND = 4'd7,
        A_OHWM  = 4'd8,
        A_STAT  = 4'd9,
        A_ENA   = 4'd10,
        A_ITAIL = 4'd11,
        A_OTAIL = 4'd12
    } reg_addr_e;

    localparam int SB_IDBOVF = 0;
    localparam int SB_ODBOVF = 1;
    localparam int SB_ITHR   = 2;
    localparam int SB_OTHR   = 3;
    localparam int SB_IUNDER = 4;
    localparam int SB_OUNDER = 5;
    localparam int SB_RXDROP = 6;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;
endpackage

// File: rtl/ring_ctrl_fsm.sv
module ring_ctrl_fsm
    import ring_dbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic ctrl_bit,
    output logic hold
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl_we && ctrl_bit)  state_d = ST_HELD; // RUN_TO_HELD
            ST_HELD: if (ctrl_we && !ctrl_bit) state_d = ST_RUN;  // HELD_TO_RUN
        endcase
    end

    always_comb begin
        hold = (state_q == ST_HELD);
    end
endmodule

// File: rtl/ring_counter.sv
module ring_counter #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          size_we,
    input  logic          hwm_we,
    input  logic          db_we,
    input  logic          sub_we,
    input  logic [CW-1:0] wdata,
    input  logic          hw_done,
    output logic [CW-1:0] size_q,
    output logic [CW-1:0] hwm_q,
    output logic [CW-1:0] posted_q,
    output logic [CW-1:0] pend_q,
    output logic [CW-1:0] tail_q,
    output logic          ev_dbovf,
    output logic          ev_under,
    output logic          ev_thresh
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] room;
    logic [CW-1:0] tail_inc;
    logic          db_ok;
    logic          sub_ok;
    logic          take;
    logic [CW-1:0] posted_d;
    logic [CW-1:0] pend_d;
    logic [CW-1:0] tail_d;

    always_comb begin
        room      = (size_q > posted_q) ? (size_q - posted_q) : '0;
        db_ok     = db_we && !hold && (wdata <= room);
        ev_dbovf  = db_we && !hold && (wdata > room);
        sub_ok    = sub_we && !hold && (wdata <= pend_q);
        ev_under  = sub_we && !hold && (wdata > pend_q);
        take      = hw_done && !hold && (posted_q != '0);
        ev_thresh = (pend_q > hwm_q);
        tail_inc  = tail_q + ONE;

        posted_d = posted_q;
        if (db_ok) posted_d = posted_d + wdata;
        if (take)  posted_d = posted_d - ONE;

        pend_d = pend_q;
        if (sub_ok) pend_d = pend_d - wdata;
        if (take)   pend_d = pend_d + ONE;

        tail_d = tail_q;
        if (take) tail_d = (tail_inc >= size_q) ? '0 : tail_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= '0;
            hwm_q    <= '0;
            posted_q <= '0;
            pend_q   <= '0;
            tail_q   <= '0;
        end else begin
            if (size_we) size_q <= wdata;
            if (hwm_we)  hwm_q  <= wdata;
            if (hold) begin
                posted_q <= '0;
                pend_q   <= '0;
                tail_q   <= '0;
            end else begin
                posted_q <= posted_d;
                pend_q   <= pend_d;
                tail_q   <= tail_d;
            end
        end
    end
endmodule

// File: rtl/ring_status.sv
module ring_status #(
    parameter int NB = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_ev,
    input  logic          clr_we,
    input  logic          ena_we,
    input  logic [NB-1:0] wdata,
    output logic [NB-1:0] stat_q,
    output logic [NB-1:0] ena_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ena_q  <= '0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (set_ev[i])                stat_q[i] <= 1'b1;
                else if (clr_we && wdata[i])  stat_q[i] <= 1'b0;
            end
            if (ena_we) ena_q <= wdata;
        end
    end

    always_comb begin
        irq = |(stat_q & ena_q);
    end
endmodule

// File: rtl/ring_doorbell_unit.sv
module ring_doorbell_unit
    import ring_dbell_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    input  logic              in_done,
    input  logic              out_done,
    input  logic              rx_drop,
    output logic              irq
);
    localparam int NRING = 2;

    logic                        hold;
    logic [NRING-1:0][CW-1:0]    size_v;
    logic [NRING-1:0][CW-1:0]    hwm_v;
    logic [NRING-1:0][CW-1:0]    posted_v;
    logic [NRING-1:0][CW-1:0]    pend_v;
    logic [NRING-1:0][CW-1:0]    tail_v;
    logic [NRING-1:0]            dbovf_v;
    logic [NRING-1:0]            under_v;
    logic [NRING-1:0]            thr_v;
    logic [NRING-1:0]            done_v;
    logic [NSTAT-1:0]            set_ev;
    logic [NSTAT-1:0]            stat_q;
    logic [NSTAT-1:0]            ena_q;

    assign done_v = {out_done, in_done};

    ring_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (wr_en && (wr_addr == A_CTRL)),
        .ctrl_bit (wr_data[0]),
        .hold     (hold)
    );

    for (genvar r = 0; r < NRING; r++) begin : g_ring
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(1 + 4 * r);
        ring_counter #(.CW(CW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (hold),
            .size_we   (wr_en && (wr_addr == BASE)),
            .db_we     (wr_en && (wr_addr == BASE + ADDR_W'(1))),
            .sub_we    (wr_en && (wr_addr == BASE + ADDR_W'(2))),
            .hwm_we    (wr_en && (wr_addr == BASE + ADDR_W'(3))),
            .wdata     (wr_data),
            .hw_done   (done_v[r]),
            .size_q    (size_v[r]),
            .hwm_q     (hwm_v[r]),
            .posted_q  (posted_v[r]),
            .pend_q    (pend_v[r]),
            .tail_q    (tail_v[r]),
            .ev_dbovf  (dbovf_v[r]),
            .ev_under  (under_v[r]),
            .ev_thresh (thr_v[r])
        );
    end

    always_comb begin
        set_ev            = '0;
        set_ev[SB_IDBOVF] = dbovf_v[0];
        set_ev[SB_ODBOVF] = dbovf_v[1];
        set_ev[SB_ITHR]   = thr_v[0];
        set_ev[SB_OTHR]   = thr_v[1];
        set_ev[SB_IUNDER] = under_v[0];
        set_ev[SB_OUNDER] = under_v[1];
        set_ev[SB_RXDROP] = rx_drop;
    end

    ring_status #(.NB(NSTAT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr_we (wr_en && (wr_addr == A_STAT)),
        .ena_we (wr_en && (wr_addr == A_ENA)),
        .wdata  (wr_data[NSTAT-1:0]),
        .stat_q (stat_q),
        .ena_q  (ena_q),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = {{(CW-1){1'b0}}, hold};
            A_ISIZE: rd_data = size_v[0];
            A_IDB:   rd_data = posted_v[0];
            A_IPEND: rd_data = pend_v[0];
            A_IHWM:  rd_data = hwm_v[0];
            A_OSIZE: rd_data = size_v[1];
            A_ODB:   rd_data = posted_v[1];
            A_OPEND: rd_data = pend_v[1];
            A_OHWM:  rd_data = hwm_v[1];
            A_STAT:  rd_data = {{(CW-NSTAT){1'b0}}, stat_q};
            A_ENA:   rd_data = {{(CW-NSTAT){1'b0}}, ena_q};
            A_ITAIL: rd_data = tail_v[0];
            A_OTAIL: rd_data = tail_v[1];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ring_doorbell_unit_chk.sv
module ring_doorbell_unit_chk #(
    parameter int CW = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [3:0]          wr_addr,
    input logic [CW-1:0]       wr_data,
    input logic                in_done,
    input logic                rx_drop,
    input logic                irq,
    input logic                hold,
    input logic [6:0]          stat_q,
    input logic [6:0]          ena_q,
    input logic [1:0][CW-1:0]  size_v,
    input logic [1:0][CW-1:0]  hwm_v,
    input logic [1:0][CW-1:0]  posted_v,
    input logic [1:0][CW-1:0]  pend_v,
    input logic [1:0][CW-1:0]  tail_v
);
    AST_DBELL_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr_en && wr_addr == 4'd2 && !in_done && size_v[0] >= posted_v[0]
         && wr_data > (size_v[0] - posted_v[0]))
        |=> ($stable(posted_v[0]) && stat_q[0])); // R4

    AST_PEND_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr_en && wr_addr == 4'd3 && wr_data > pend_v[0]) |=> stat_q[4]); // R5

    AST_THRESH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v[1] > hwm_v[1]) |=> stat_q[3]); // R6

    AST_RX_DROP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> stat_q[6]); // R7

    AST_TAIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && in_done && posted_v[0] != '0 && size_v[0] != '0
         && tail_v[0] == size_v[0] - CW'(1)) |=> (tail_v[0] == '0)); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq); // R9

    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> (posted_v == '0 && pend_v == '0 && tail_v == '0)); // R10
endmodule

bind ring_doorbell_unit ring_doorbell_unit_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .in_done  (in_done),
    .rx_drop  (rx_drop),
    .irq      (irq),
    .hold     (hold),
    .stat_q   (stat_q),
    .ena_q    (ena_q),
    .size_v   (size_v),
    .hwm_v    (hwm_v),
    .posted_v (posted_v),
    .pend_v   (pend_v),
    .tail_v   (tail_v)
);

// File: tb/tb_ring_doorbell_unit.sv
module tb_ring_doorbell_unit;
    localparam int CW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          in_done = 1'b0;
    logic          out_done = 1'b0;
    logic          rx_drop = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ring_doorbell_unit #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .in_done(in_done), .out_done(out_done), .rx_drop(rx_drop), .irq(irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a, input int exp);
        int v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic chk_bit(input string tag, input int b, input int exp);
        int v;
        rd(4'd9, v);
        check(tag, (v >> b) & 1, exp);
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_in;
        @(negedge clk); in_done = 1'b1;
        @(negedge clk); in_done = 1'b0;
    endtask

    task automatic pulse_out;
        @(negedge clk); out_done = 1'b1;
        @(negedge clk); out_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R10 / R1: every register reads zero after reset
        for (int a = 0; a < 13; a++) chk_reg("R10 reset value", 4'(a), 0);
        check("R9 irq after reset", int'(irq), 0);

        // inbound ring of 8 entries
        wr(4'd1, 8);
        chk_reg("R1 size readback", 4'd1, 8);
        wr(4'd2, 5);
        chk_reg("R2 doorbell adds", 4'd2, 5);
        wr(4'd2, 4);
        chk_reg("R4 oversize doorbell discarded", 4'd2, 5);
        chk_bit("R4 inbound overflow bit0", 0, 1);
        wr(4'd2, 3);
        chk_reg("R4 doorbell equal to room accepted", 4'd2, 8);

        // R3: completion sweep past the posted count
        for (int k = 1; k <= 10; k++) begin
            int used;
            pulse_in();
            used = (k < 8) ? k : 8;
            chk_reg("R3 inbound tail", 4'd11, used % 8);
            chk_reg("R3 inbound pending", 4'd3, used);
            chk_reg("R3 inbound posted", 4'd2, 8 - used);
        end

        // R5: subtractive pending writes
        wr(4'd3, 3);
        chk_reg("R5 subtract", 4'd3, 5);
        wr(4'd3, 6);
        chk_reg("R5 underflow leaves count", 4'd3, 5);
        chk_bit("R5 underflow bit4", 4, 1);
        wr(4'd3, 5);
        chk_reg("R5 subtract to zero", 4'd3, 0);

        // R8: write-1-to-clear
        wr(4'd9, 7'h7F);
        idle(1);
        chk_reg("R8 status cleared", 4'd9, 0);

        // R6: threshold, equality does not trip
        wr(4'd4, 2);
        wr(4'd2, 4);
        pulse_in(); pulse_in();
        idle(1);
        chk_reg("R6 pending at mark", 4'd3, 2);
        chk_bit("R6 equal does not set bit2", 2, 0);
        pulse_in();
        idle(1);
        chk_bit("R6 above mark sets bit2", 2, 1);
        wr(4'd9, 4);
        chk_bit("R8 clear loses to live set", 2, 1);

        // R2: doorbell and completion in one cycle (posted 1, pend 3, tail 3)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = CW'(1); in_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; in_done = 1'b0;
        chk_reg("R2 same-cycle posted", 4'd2, 1);
        chk_reg("R3 same-cycle pending", 4'd3, 4);
        chk_reg("R3 same-cycle tail", 4'd11, 4);

        // R9 / R7: interrupt masking
        check("R9 irq masked", int'(irq), 0);
        wr(4'd10, 4);
        check("R9 irq enabled bit2", int'(irq), 1);
        wr(4'd10, 1);
        check("R9 irq enable on clear bit", int'(irq), 0);
        @(negedge clk); rx_drop = 1'b1;
        @(negedge clk); rx_drop = 1'b0;
        chk_bit("R7 rx drop bit6", 6, 1);
        wr(4'd10, 7'h40);
        check("R9 irq on rx drop", int'(irq), 1);
        chk_reg("R1 enable readback", 4'd10, 7'h40);
        wr(4'd9, 7'h40);
        check("R8 R9 irq after clear", int'(irq), 0);

        // outbound sweep over ring sizes
        for (int sz = 1; sz <= 6; sz++) begin
            wr(4'd0, 1);
            idle(1);
            wr(4'd0, 0);
            wr(4'd5, sz);
            wr(4'd6, sz);
            chk_reg("R2 outbound posted", 4'd6, sz);
            for (int k = 1; k <= sz + 2; k++) begin
                int used;
                pulse_out();
                used = (k < sz) ? k : sz;
                chk_reg("R3 outbound tail", 4'd12, used % sz);
                chk_reg("R3 outbound pending", 4'd7, used);
                chk_reg("R3 outbound posted", 4'd6, sz - used);
            end
            wr(4'd6, sz + 1);
            chk_reg("R4 outbound oversize", 4'd6, 0);
            chk_bit("R4 outbound overflow bit1", 1, 1);
            wr(4'd7, sz + 1);
            chk_reg("R5 outbound underflow count", 4'd7, sz);
            chk_bit("R5 outbound underflow bit5", 5, 1);
            wr(4'd9, 7'h22);
            chk_bit("R8 bit1 cleared", 1, 0);
            chk_bit("R8 bit5 cleared", 5, 0);
        end

        // R10: soft reset hold
        wr(4'd0, 1);
        idle(1);
        chk_reg("R10 control reads held", 4'd0, 1);
        chk_reg("R10 posted zero", 4'd2, 0);
        chk_reg("R10 pending zero", 4'd3, 0);
        chk_reg("R10 tail zero", 4'd11, 0);
        chk_reg("R10 size kept", 4'd1, 8);
        chk_reg("R10 mark kept", 4'd4, 2);
        wr(4'd2, 3);
        chk_reg("R10 doorbell ignored", 4'd2, 0);
        pulse_in();
        chk_reg("R10 completion ignored", 4'd3, 0);
        wr(4'd6, 1);
        chk_bit("R10 no overflow while held", 1, 0);
        wr(4'd0, 0);
        wr(4'd2, 3);
        chk_reg("R10 doorbell after release", 4'd2, 3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule